// File: doc/BRIEF.md
# Way-Limited Set-Associative Tag Store

This block holds the tag side of a set-associative cache. Each line of each set keeps a tag, a valid bit, a secure-space bit, a hit reference count and the cycle at which the line's contents become usable. A single command port takes lookup, insert, invalidate and way-limit commands, one per cycle. A response appears in the cycle after a command is accepted.

A lookup reports hit or miss, the way that hit and an access latency in cycles. It also names a victim way for a later insert, and gives the full block address of the line held in that way. Lookups, victim choice and activity accounting only use a programmable number of allocatable ways, counted from way 0. Running counters record tag-array reads, data-array reads, replacements and the reference counts of evicted lines. A mode input selects sequential access, where data is read only after a tag hit, or parallel access, where data is read in every allocatable way.

Top module: `tag_store`

## Requirements
- R1: The set index is `(cmd_addr >> OFF_W) & (SETS-1)` and the tag is `cmd_addr >> (OFF_W + log2(SETS))`. The offset bits below OFF_W play no part in matching.
- R2: A lookup hits when a way below the allocatable limit is valid, holds the request's tag and has a secure bit equal to `cmd_secure`. If several ways match, `rsp_way` is the lowest of them. Ways at or above the limit never hit.
- R3: Every lookup adds the allocatable way count to `tag_access_cnt`.
- R4: With `seq_mode`=1, a lookup adds 1 to `data_access_cnt` on a hit and 0 on a miss. With `seq_mode`=0, it adds the allocatable way count.
- R5: A hit reports latency ACC_LAT. If the line's ready cycle minus the current cycle count is greater than ACC_LAT, it reports that difference plus ACC_LAT instead. The ready cycle is the insert cycle plus `cmd_delay`.
- R6: A miss reports latency LKP_LAT.
- R7: Each hit adds one to the reference count of the line that hit.
- R8: The victim is the lowest invalid way below the limit. If all of those ways are valid, the victim is the way numbered limit-1.
- R9: Op 3 sets the limit to `cmd_limit`. A value of 0 or a value above WAYS is refused: `rsp_err`=1 and the previous limit stays.
- R10: An insert (op 1) into a valid line adds 1 to `repl_cnt`, adds that line's reference count to `ref_total` and zeroes the count. Every insert adds exactly 1 to both access counters.
- R11: `rsp_victim_addr` equals the victim's stored tag shifted left by the tag shift, ORed with the set shifted left by OFF_W.
- R12: Invalidate (op 2) clears the valid bit at the addressed set and `cmd_way`.
- R13: After reset, all lines are invalid with zero contents, all counters and the cycle count are 0, the limit is WAYS and `rsp_valid` is 0. Op codes: 0 lookup, 1 insert, 2 invalidate, 3 set limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_mode | input | 1 | 1 selects sequential data access, 0 selects parallel |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted (always 1 outside reset) |
| cmd_op | input | 2 | 0 lookup, 1 insert, 2 invalidate, 3 set limit |
| cmd_addr | input | ADDR_W | Request address |
| cmd_secure | input | 1 | Secure-space bit of the request |
| cmd_way | input | log2(WAYS) | Target way for insert and invalidate |
| cmd_delay | input | TIME_W | Cycles until an inserted line is ready |
| cmd_limit | input | log2(WAYS+1) | New allocatable way count |
| rsp_valid | output | 1 | Response present |
| rsp_op | output | 2 | Op of the command answered |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | log2(WAYS) | Way that hit |
| rsp_lat | output | TIME_W | Reported latency in cycles |
| rsp_victim | output | log2(WAYS) | Victim way for the looked-up set |
| rsp_victim_addr | output | ADDR_W | Block address rebuilt from the victim line |
| rsp_err | output | 1 | Limit command refused |
| alloc_ways | output | log2(WAYS+1) | Current allocatable way count |
| tag_access_cnt | output | CNT_W | Tag-array reads |
| data_access_cnt | output | CNT_W | Data-array reads |
| repl_cnt | output | CNT_W | Inserts that displaced a valid line |
| ref_total | output | CNT_W | Sum of reference counts of displaced lines |

## Verification
The assertions assume that an insert's `cmd_way` is below WAYS and that the cycle count does not wrap between an insert and the lookups that depend on its ready cycle. The stimulus picks ways from 0 to WAYS-1 only and keeps the whole run far below 2^TIME_W cycles, with delays of at most 15 cycles. Tags are drawn from a small pool that includes both very high and very low tag bits. Offset bits are random, and limit commands sometimes carry the refused values 0 and WAYS+1. This gives frequent hits, duplicate tags across ways, and lines that are full or only partly valid.

// File: rtl/tagstore_pkg.sv
package tagstore_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_INVAL  = 2'd2,
        OP_SETLIM = 2'd3
    } ts_op_e;

    // limit value accepted when inside 1..ways
    function automatic logic limit_ok(input int unsigned value, input int unsigned ways);
        return (value >= 1) && (value <= ways);
    endfunction
endpackage

// File: rtl/tagstore_match.sv
module tagstore_match #(
    parameter int WAYS  = 4,
    parameter int TAG_W = 25,
    localparam int WAY_W = $clog2(WAYS),
    localparam int LIM_W = $clog2(WAYS + 1)
) (
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAYS-1:0]  secure_vec,
    input  logic [TAG_W-1:0] tag_vec [WAYS],
    input  logic [TAG_W-1:0] req_tag,
    input  logic             req_secure,
    input  logic [LIM_W-1:0] limit,
    output logic             hit,
    output logic [WAY_W-1:0] hit_way,
    output logic [WAY_W-1:0] victim_way
);
    logic [WAYS-1:0] way_match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign way_match[w] = (LIM_W'(w) < limit) && valid_vec[w]
                              && (secure_vec[w] == req_secure)
                              && (tag_vec[w] == req_tag);
    end

    always_comb begin
        logic found;
        hit        = |way_match;
        hit_way    = '0;
        victim_way = WAY_W'(limit - LIM_W'(1));
        found      = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (way_match[w]) hit_way = WAY_W'(w);
        end
        for (int w = 0; w < WAYS; w++) begin
            if (!found && (LIM_W'(w) < limit) && !valid_vec[w]) begin
                victim_way = WAY_W'(w);
                found      = 1'b1;
            end
        end
    end
endmodule

// File: rtl/tagstore_latency.sv
module tagstore_latency #(
    parameter int TIME_W  = 16,
    parameter int ACC_LAT = 2,
    parameter int LKP_LAT = 1
) (
    input  logic              hit,
    input  logic [TIME_W-1:0] ready_at,
    input  logic [TIME_W-1:0] now,
    output logic [TIME_W-1:0] lat
);
    logic [TIME_W-1:0] wait_left;

    always_comb begin
        wait_left = ready_at - now;
        if (!hit) begin
            lat = TIME_W'(LKP_LAT);
        end else if (!wait_left[TIME_W-1] && (wait_left > TIME_W'(ACC_LAT))) begin
            lat = wait_left + TIME_W'(ACC_LAT);
        end else begin
            lat = TIME_W'(ACC_LAT);
        end
    end
endmodule

// File: rtl/tagstore_stats.sv
module tagstore_stats #(
    parameter int WAYS  = 4,
    parameter int REF_W = 16,
    parameter int CNT_W = 32,
    localparam int LIM_W = $clog2(WAYS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_fire,
    input  logic             ins_fire,
    input  logic             hit,
    input  logic             seq_mode,
    input  logic [LIM_W-1:0] limit,
    input  logic             evict,
    input  logic [REF_W-1:0] evict_refs,
    output logic [CNT_W-1:0] tag_cnt,
    output logic [CNT_W-1:0] data_cnt,
    output logic [CNT_W-1:0] repl_cnt,
    output logic [CNT_W-1:0] ref_sum
);
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_cnt  <= '0;
            data_cnt <= '0;
            repl_cnt <= '0;
            ref_sum  <= '0;
        end else begin
            if (lk_fire) begin
                tag_cnt <= tag_cnt + CNT_W'(limit);
                if (!seq_mode)  data_cnt <= data_cnt + CNT_W'(limit);
                else if (hit)   data_cnt <= data_cnt + CNT_W'(1);
            end else if (ins_fire) begin
                tag_cnt  <= tag_cnt + CNT_W'(1);
                data_cnt <= data_cnt + CNT_W'(1);
                if (evict) begin
                    repl_cnt <= repl_cnt + CNT_W'(1);
                    ref_sum  <= ref_sum + CNT_W'(evict_refs);
                end
            end
        end
    end

    p_tag_step_r3: assert property (@(posedge clk) disable iff (rst)
        (tag_cnt - $past(tag_cnt)) <= CNT_W'(WAYS));
    p_data_le_tag_r4: assert property (@(posedge clk) disable iff (rst)
        data_cnt <= tag_cnt);
    p_repl_step_r10: assert property (@(posedge clk) disable iff (rst)
        (repl_cnt - $past(repl_cnt)) <= CNT_W'(1));
    p_seq_miss_r4: assert property (@(posedge clk) disable iff (rst)
        (lk_fire && seq_mode && !hit) |=> $stable(data_cnt));
endmodule

// File: rtl/tag_store.sv
module tag_store
    import tagstore_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int SETS    = 8,
    parameter int WAYS    = 4,
    parameter int OFF_W   = 4,
    parameter int TIME_W  = 16,
    parameter int REF_W   = 16,
    parameter int CNT_W   = 32,
    parameter int ACC_LAT = 2,
    parameter int LKP_LAT = 1
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       seq_mode,
    input  logic                       cmd_valid,
    output logic                       cmd_ready,
    input  logic [1:0]                 cmd_op,
    input  logic [ADDR_W-1:0]          cmd_addr,
    input  logic                       cmd_secure,
    input  logic [$clog2(WAYS)-1:0]    cmd_way,
    input  logic [TIME_W-1:0]          cmd_delay,
    input  logic [$clog2(WAYS+1)-1:0]  cmd_limit,
    output logic                       rsp_valid,
    output logic [1:0]                 rsp_op,
    output logic                       rsp_hit,
    output logic [$clog2(WAYS)-1:0]    rsp_way,
    output logic [TIME_W-1:0]          rsp_lat,
    output logic [$clog2(WAYS)-1:0]    rsp_victim,
    output logic [ADDR_W-1:0]          rsp_victim_addr,
    output logic                       rsp_err,
    output logic [$clog2(WAYS+1)-1:0]  alloc_ways,
    output logic [CNT_W-1:0]           tag_access_cnt,
    output logic [CNT_W-1:0]           data_access_cnt,
    output logic [CNT_W-1:0]           repl_cnt,
    output logic [CNT_W-1:0]           ref_total
);
    localparam int SET_W     = $clog2(SETS);
    localparam int WAY_W     = $clog2(WAYS);
    localparam int LIM_W     = $clog2(WAYS + 1);
    localparam int TAG_SHIFT = OFF_W + SET_W;
    localparam int TAG_W     = ADDR_W - TAG_SHIFT;

    typedef struct packed {
        logic              valid;
        logic              secure;
        logic [TAG_W-1:0]  tag;
        logic [REF_W-1:0]  refs;
        logic [TIME_W-1:0] ready;
    } line_t;

    line_t              lines [SETS][WAYS];
    logic [TIME_W-1:0]  now;
    logic [SET_W-1:0]   set_idx;
    logic [TAG_W-1:0]   req_tag;
    logic [WAYS-1:0]    valid_vec, secure_vec;
    logic [TAG_W-1:0]   tag_vec [WAYS];
    logic               hit;
    logic [WAY_W-1:0]   hit_way, victim_way;
    logic [TIME_W-1:0]  lat;
    logic               lk_fire, ins_fire, evict;
    line_t              hit_line, vic_line, ins_line;
    ts_op_e             op;

    assign op        = ts_op_e'(cmd_op);
    assign cmd_ready = !rst;
    assign set_idx   = SET_W'(cmd_addr >> OFF_W);
    assign req_tag   = TAG_W'(cmd_addr >> TAG_SHIFT);
    assign lk_fire   = cmd_valid && (op == OP_LOOKUP);
    assign ins_fire  = cmd_valid && (op == OP_INSERT) && (int'(cmd_way) < WAYS);
    assign hit_line  = lines[set_idx][hit_way];
    assign vic_line  = lines[set_idx][victim_way];
    assign ins_line  = lines[set_idx][cmd_way];
    assign evict     = ins_line.valid;

    for (genvar w = 0; w < WAYS; w++) begin : g_view
        assign valid_vec[w]  = lines[set_idx][w].valid;
        assign secure_vec[w] = lines[set_idx][w].secure;
        assign tag_vec[w]    = lines[set_idx][w].tag;
    end

    tagstore_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
        .valid_vec(valid_vec), .secure_vec(secure_vec), .tag_vec(tag_vec),
        .req_tag(req_tag), .req_secure(cmd_secure), .limit(alloc_ways),
        .hit(hit), .hit_way(hit_way), .victim_way(victim_way)
    );

    tagstore_latency #(.TIME_W(TIME_W), .ACC_LAT(ACC_LAT), .LKP_LAT(LKP_LAT)) u_lat (
        .hit(hit), .ready_at(hit_line.ready), .now(now), .lat(lat)
    );

    tagstore_stats #(.WAYS(WAYS), .REF_W(REF_W), .CNT_W(CNT_W)) u_stats (
        .clk(clk), .rst(rst), .lk_fire(lk_fire), .ins_fire(ins_fire), .hit(hit),
        .seq_mode(seq_mode), .limit(alloc_ways), .evict(evict),
        .evict_refs(ins_line.refs), .tag_cnt(tag_access_cnt),
        .data_cnt(data_access_cnt), .repl_cnt(repl_cnt), .ref_sum(ref_total)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                for (int w = 0; w < WAYS; w++)
                    lines[s][w] <= '0;
            now             <= '0;
            alloc_ways      <= LIM_W'(WAYS);
            rsp_valid       <= 1'b0;
            rsp_op          <= '0;
            rsp_hit         <= 1'b0;
            rsp_way         <= '0;
            rsp_lat         <= '0;
            rsp_victim      <= '0;
            rsp_victim_addr <= '0;
            rsp_err         <= 1'b0;
        end else begin
            now       <= now + TIME_W'(1);
            rsp_valid <= cmd_valid;
            if (cmd_valid) begin
                rsp_op  <= cmd_op;
                rsp_hit <= 1'b0;
                rsp_err <= 1'b0;
                unique case (op)
                    OP_LOOKUP: begin
                        rsp_hit         <= hit;
                        rsp_way         <= hit_way;
                        rsp_lat         <= lat;
                        rsp_victim      <= victim_way;
                        rsp_victim_addr <= (ADDR_W'(vic_line.tag) << TAG_SHIFT)
                                         | (ADDR_W'(set_idx) << OFF_W);
                        if (hit)
                            lines[set_idx][hit_way].refs <= hit_line.refs + REF_W'(1);
                    end
                    OP_INSERT: begin
                        if (ins_fire) begin
                            lines[set_idx][cmd_way].valid  <= 1'b1;
                            lines[set_idx][cmd_way].secure <= cmd_secure;
                            lines[set_idx][cmd_way].tag    <= req_tag;
                            lines[set_idx][cmd_way].refs   <= '0;
                            lines[set_idx][cmd_way].ready  <= now + cmd_delay;
                        end
                    end
                    OP_INVAL: begin
                        if (int'(cmd_way) < WAYS)
                            lines[set_idx][cmd_way].valid <= 1'b0;
                    end
                    OP_SETLIM: begin
                        if (limit_ok(int'(cmd_limit), WAYS)) alloc_ways <= cmd_limit;
                        else                                 rsp_err    <= 1'b1;
                    end
                endcase
            end
        end
    end

    p_limit_range_r9: assert property (@(posedge clk) disable iff (rst)
        (alloc_ways >= LIM_W'(1)) && (alloc_ways <= LIM_W'(WAYS)));
    p_reject_keeps_r9: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_op == OP_SETLIM && rsp_err) |-> $stable(alloc_ways));
    p_hit_in_limit_r2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (LIM_W'(rsp_way) < alloc_ways));
    p_victim_in_limit_r8: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_op == OP_LOOKUP) |-> (LIM_W'(rsp_victim) < alloc_ways));
    p_miss_lat_r6: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_op == OP_LOOKUP && !rsp_hit) |-> (rsp_lat == TIME_W'(LKP_LAT)));
    p_hit_lat_floor_r5: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_hit) |-> (rsp_lat >= TIME_W'(ACC_LAT)));
endmodule

// File: tb/tag_store_bench.sv
module tag_store_bench;
    localparam int ADDR_W = 32, SETS = 8, WAYS = 4, OFF_W = 4, TIME_W = 16;
    localparam int ACC = 2, LKP = 1, TSH = 7;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic rst, seq_mode, cmd_valid, cmd_ready, cmd_secure;
    logic [1:0] cmd_op, rsp_op;
    logic [ADDR_W-1:0] cmd_addr, rsp_victim_addr;
    logic [1:0] cmd_way, rsp_way, rsp_victim;
    logic [TIME_W-1:0] cmd_delay, rsp_lat;
    logic [2:0] cmd_limit, alloc_ways;
    logic rsp_valid, rsp_hit, rsp_err;
    logic [31:0] tag_access_cnt, data_access_cnt, repl_cnt, ref_total;

    tag_store u_tag_store (.*);

    int checks = 0, errors = 0, now_m = 0;
    bit done = 0;
    bit mv [SETS][WAYS];
    bit ms [SETS][WAYS];
    int mt [SETS][WAYS];
    int mref [SETS][WAYS];
    int mrdy [SETS][WAYS];
    int mlim;
    longint etag, edata, erepl, eref;

    always @(posedge clk) now_m <= rst ? 0 : now_m + 1;

    task automatic chk(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int exp_lat(int s, int w, bit h);
        int rem;
        if (!h) return LKP;
        rem = mrdy[s][w] - now_m;
        return (rem > ACC) ? rem + ACC : ACC;
    endfunction

    task automatic issue(int op, int tag, int s, bit sec, int way, int dly, int lim);
        bit h = 0; int hw = 0, vic, lat; bit found = 0; bit err = 0;
        longint vaddr;
        if (op == 0) begin
            for (int w = 0; w < mlim; w++)
                if (!h && mv[s][w] && mt[s][w] == tag && ms[s][w] == sec) begin h = 1; hw = w; end
            vic = mlim - 1;
            for (int w = 0; w < mlim; w++)
                if (!found && !mv[s][w]) begin vic = w; found = 1; end
            lat = exp_lat(s, hw, h);
            vaddr = ((longint'(mt[s][vic]) << TSH) | (longint'(s) << OFF_W)) & 64'hFFFF_FFFF;
        end
        cmd_valid  = 1;
        cmd_op     = 2'(op);
        cmd_addr   = (32'(tag) << TSH) | (32'(s) << OFF_W) | 32'($urandom % 16);
        cmd_secure = sec;
        cmd_way    = 2'(way);
        cmd_delay  = 16'(dly);
        cmd_limit  = 3'(lim);
        case (op)
            0: begin
                etag += mlim;
                edata += seq_mode ? (h ? 1 : 0) : mlim;
                if (h) mref[s][hw]++;
            end
            1: begin
                if (mv[s][way]) begin erepl++; eref += mref[s][way]; end
                mv[s][way] = 1; ms[s][way] = sec; mt[s][way] = tag;
                mref[s][way] = 0; mrdy[s][way] = now_m + dly;
                etag++; edata++;
            end
            2: mv[s][way] = 0;
            default: if (lim < 1 || lim > WAYS) err = 1; else mlim = lim;
        endcase
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        chk("R13 rsp_valid", rsp_valid, 1);
        chk("R13 rsp_op", rsp_op, op);
        if (op == 0) begin
            chk("R1 R2 hit", rsp_hit, h);
            if (h) chk("R2 hit way", rsp_way, hw);
            chk(h ? "R5 hit latency" : "R6 miss latency", rsp_lat, lat);
            chk("R8 victim", rsp_victim, vic);
            chk("R11 victim address", rsp_victim_addr, vaddr);
        end
        if (op == 3) begin
            chk("R9 error flag", rsp_err, err);
            chk("R9 limit", alloc_ways, mlim);
        end
        chk("R3 tag accesses", tag_access_cnt, etag);
        chk("R4 data accesses", data_access_cnt, edata);
        chk("R10 replacements", repl_cnt, erepl);
        chk("R7 R10 reference total", ref_total, eref);
    endtask

    function automatic int pick_tag();
        case ($urandom % 4)
            0: return 0;
            1: return 1;
            2: return 32'h0100_0000;
            default: return 32'h01FF_FFFF;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        rst = 1; seq_mode = 1; cmd_valid = 0; cmd_op = 0; cmd_addr = 0;
        cmd_secure = 0; cmd_way = 0; cmd_delay = 0; cmd_limit = 0;
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) begin
                mv[s][w] = 0; ms[s][w] = 0; mt[s][w] = 0; mref[s][w] = 0; mrdy[s][w] = 0;
            end
        mlim = WAYS; etag = 0; edata = 0; erepl = 0; eref = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R13 reset state
        chk("R13 rsp_valid after reset", rsp_valid, 0);
        chk("R13 limit after reset", alloc_ways, WAYS);
        chk("R13 counters after reset", tag_access_cnt + data_access_cnt + repl_cnt + ref_total, 0);
        // R6/R8 empty set
        issue(0, 5, 2, 0, 0, 0, 0);
        // R5 stretched latency, then plain latency later
        issue(1, 5, 2, 0, 0, 10, 0);
        issue(0, 5, 2, 0, 0, 0, 0);
        // R2 secure mismatch misses
        issue(0, 5, 2, 1, 0, 0, 0);
        repeat (12) @(negedge clk);
        issue(0, 5, 2, 0, 0, 0, 0);
        // R9 refused limits and a good one
        issue(3, 0, 0, 0, 0, 0, 0);
        issue(3, 0, 0, 0, 0, 0, 5);
        issue(3, 0, 0, 0, 0, 0, 2);
        // R8 full allocatable ways -> last allowed way; R2 way beyond limit unseen
        issue(1, 6, 2, 0, 1, 0, 0);
        issue(1, 9, 2, 0, 3, 0, 0);
        issue(0, 9, 2, 0, 0, 0, 0);
        // R12 invalidate frees way 0
        issue(2, 5, 2, 0, 0, 0, 0);
        issue(0, 5, 2, 0, 0, 0, 0);
        // R7 R10 hits build references, then a replacement
        issue(0, 6, 2, 0, 0, 0, 0);
        issue(0, 6, 2, 0, 0, 0, 0);
        issue(1, 7, 2, 0, 1, 0, 0);
        seq_mode = 0;
        issue(0, 7, 2, 0, 0, 0, 0);
        issue(3, 0, 0, 0, 0, 0, 4);
        // random mix
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom % 100;
            int s = $urandom % SETS;
            if (i % 500 == 0) seq_mode = ~seq_mode;
            if (r < 55)      issue(0, pick_tag(), s, $urandom % 2, 0, 0, 0);
            else if (r < 85) issue(1, pick_tag(), s, $urandom % 2, $urandom % WAYS, $urandom % 16, 0);
            else if (r < 95) issue(2, 0, s, 0, $urandom % WAYS, 0, 0);
            else             issue(3, 0, 0, 0, 0, 0, $urandom % 6);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule